// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers interrupt sources organised as numbered 32-bit sets and raises one of two requests toward a processor. A flat source line number `n` names set `n / 32`, bit `n % 32`. A fixed table places a handful of sources on a high tier with levels 1 to 15. Those sources skip the per-bit enables and are filtered by a per-level mask instead. Every other source is on the low tier and is gated by its own enable bit.

Software reaches the block through a simple synchronous register port. Each source set has a status register (read the latched pending bits), an enable register and a write-one-to-clear register. Set 6 is not a source set. Its status address returns a summary word: the highest active level plus HIGH and LOW flags. Its enable address is the control word, which holds the global enable and the level mask. A group of external pins is edge-detected, and each rising or falling edge is latched into its own status bit.

Top module: `icu_two_tier`

## Requirements
- R1: A one-cycle pulse on a source line of sets 1 to 5 or 7 sets that status bit, whatever the enables or the control word hold. Status bits never set without a pulse. Lines of set 0 and set 6 latch nothing, and set 0's status reads 0.
- R2: A write to a set's clear register (kind 2) clears exactly the status bits that are 1 in the written word. If a pulse hits the same bit in the same cycle, the bit stays set.
- R3: A low-tier source is enabled by its own bit in that set's enable register (kind 1). While the global enable is set, any enabled pending low source drives `irqLow` high, unless R9 applies. A pending source that is not enabled leaves `irqLow` low.
- R4: The high tier and its levels are fixed:
  - set 5 bits 25 and 24: level 15
  - set 5 bit 30: level 14
  - set 5 bit 29: level 13
  - set 1 bit 18: level 4
  - set 1 bit 17: level 3
  - set 1 bit 27: level 2
  - set 5 bits 7 and 0: level 1
- R5: A pending high source counts only when control-word bit L is 1, where L is its level. Enable-register bits at high-tier positions have no effect on either request.
- R6: The priority vector is the highest level that has a pending, masked-in source, or 0 if there is none. Sources that share a level report that level.
- R7: The summary word (set 6, kind 0) holds the vector in bits [3:0]. Bit 8 is the LOW flag: some enabled low source is pending. Bit 9 is the HIGH flag: the vector is non-zero. All other bits read 0.
- R8: Control-word bit 0 is the global enable. While it is 0, both `irqHigh` and `irqLow` stay low, and status keeps latching. `irqHigh` is high when the global enable is 1 and the vector is non-zero.
- R9: `irqLow` is held low whenever `irqHigh` is high.
- R10: Reset clears all status, enable and control state, so both requests and the summary word read 0.
- R11: Pin i sets set 5 bit 7+i on a rising edge and set 5 bit i on a falling edge. Pins are taken as low at reset.
- R12: The register address is {set, kind}. Kind 0 is status, kind 1 is enable, kind 2 is clear and kind 3 is spare. Writes to status or spare addresses are ignored, and spare and clear addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcPulse | input | NUM_SETS*32 | One-cycle source pulses, indexed by line number |
| pinIn | input | NUM_PINS | Synchronous external pins, edge-detected |
| wrEn | input | 1 | Register write strobe |
| addr | input | SET_W+2 | Register address {set, kind} |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data (combinational from addr) |
| irqHigh | output | 1 | High-tier request |
| irqLow | output | 1 | Low-tier request |

## Verification
The assertions check on every cycle that a clear write removes exactly the written bits unless a pulse arrives at the same time, that a pulse always lands in status, that no status bit rises on its own, that clearing the global enable silences both requests, and that reset leaves the requests low. The level table, the winner among several levels, shared levels, mask gating, the precedence of the high tier, pin edge mapping and the address map can only be shown by the bench's scenarios. Those scenarios sweep every low bit of every source set, every high entry and every pin.

// File: rtl/icu_pkg.sv
package icu_pkg;

  localparam int WORD_W    = 32;
  localparam int LEVEL_W   = 4;
  localparam int NUM_LEVEL = 15;

  typedef enum logic [1:0] {
    KIND_STATUS = 2'd0,
    KIND_ENABLE = 2'd1,
    KIND_CLEAR  = 2'd2,
    KIND_SPARE  = 2'd3
  } reg_kind_e;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_ENABLE,
    RD_SUMMARY,
    RD_CONTROL
  } rd_sel_e;

  typedef struct packed {
    logic    wrEnable;
    logic    wrClear;
    logic    wrControl;
    rd_sel_e rdSel;
  } icu_strobe_t;

  // Fixed high-tier level of a source; 0 means low tier.
  function automatic logic [LEVEL_W-1:0] srcLevel(input int unsigned setIdx,
                                                  input int unsigned bitIdx);
    logic [LEVEL_W-1:0] lvl;
    lvl = '0;
    if (setIdx == 5) begin
      case (bitIdx)
        24, 25:  lvl = 4'd15;
        30:      lvl = 4'd14;
        29:      lvl = 4'd13;
        0, 7:    lvl = 4'd1;
        default: lvl = '0;
      endcase
    end else if (setIdx == 1) begin
      case (bitIdx)
        18:      lvl = 4'd4;
        17:      lvl = 4'd3;
        27:      lvl = 4'd2;
        default: lvl = '0;
      endcase
    end
    return lvl;
  endfunction

  function automatic logic [WORD_W-1:0] highMaskOf(input int unsigned setIdx);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = 0; b < WORD_W; b++) begin
      m[b] = (srcLevel(setIdx, b) != '0);
    end
    return m;
  endfunction

endpackage

// File: rtl/icu_edge.sv
module icu_edge #(
  parameter int NUM_PINS = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinRise,
  output logic [NUM_PINS-1:0] pinFall
);

  logic [NUM_PINS-1:0] pinPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= pinIn;
  end

  assign pinRise = pinIn & ~pinPrev;
  assign pinFall = ~pinIn & pinPrev;

endmodule

// File: rtl/icu_ctrl.sv
module icu_ctrl
  import icu_pkg::*;
#(
  parameter int NUM_SETS    = 8,
  parameter int SUMMARY_SET = 6,
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int ADDR_W     = SET_W + 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output icu_strobe_t       strobe,
  output logic [SET_W-1:0]  setIdx
);

  localparam logic [SET_W-1:0] SUM_IDX = SET_W'(SUMMARY_SET);

  reg_kind_e kind;
  logic      isSummary;

  assign setIdx    = addr[ADDR_W-1:2];
  assign kind      = reg_kind_e'(addr[1:0]);
  assign isSummary = (setIdx == SUM_IDX);

  always_comb begin
    strobe.wrEnable  = wrEn && (kind == KIND_ENABLE) && !isSummary;
    strobe.wrControl = wrEn && (kind == KIND_ENABLE) && isSummary;
    strobe.wrClear   = wrEn && (kind == KIND_CLEAR) && !isSummary;
    case (kind)
      KIND_STATUS: strobe.rdSel = isSummary ? RD_SUMMARY : RD_STATUS;
      KIND_ENABLE: strobe.rdSel = isSummary ? RD_CONTROL : RD_ENABLE;
      default:     strobe.rdSel = RD_NONE;
    endcase
  end

endmodule

// File: rtl/icu_datapath.sv
module icu_datapath
  import icu_pkg::*;
#(
  parameter int NUM_SETS    = 8,
  parameter int SUMMARY_SET = 6,
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int LINE_W     = NUM_SETS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  icu_strobe_t       strobe,
  input  logic [SET_W-1:0]  setIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LINE_W-1:0] pulseFlat,
  output logic [WORD_W-1:0] rdData,
  output logic [LINE_W-1:0] statusFlat,
  output logic              globalEn,
  output logic              highFlag,
  output logic              lowFlag
);

  logic [WORD_W-1:0]  statusQ [NUM_SETS];
  logic [WORD_W-1:0]  enableQ [NUM_SETS];
  logic [NUM_SETS-1:0] lowPend;
  logic [15:0]         ctrlQ;
  logic [15:0]         levelPend;
  logic [15:0]         levelLive;
  logic [LEVEL_W-1:0]  vector;

  // Per-set status and enable storage
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    if (s == 0 || s == SUMMARY_SET) begin : g_none
      logic unusedPulse;
      assign unusedPulse = ^pulseFlat[s*WORD_W +: WORD_W];
      assign statusQ[s]  = '0;
      assign enableQ[s]  = '0;
      assign lowPend[s]  = 1'b0;
    end else begin : g_src
      localparam logic [WORD_W-1:0] HIGH_MASK = highMaskOf(s);
      logic [WORD_W-1:0] statusR;
      logic [WORD_W-1:0] enableR;
      logic [WORD_W-1:0] clrWord;
      logic              hitSet;

      assign hitSet  = (setIdx == SET_W'(s));
      assign clrWord = (strobe.wrClear && hitSet) ? wrData : '0;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statusR <= '0;
          enableR <= '0;
        end else begin
          statusR <= (statusR & ~clrWord) | pulseFlat[s*WORD_W +: WORD_W];
          if (strobe.wrEnable && hitSet) enableR <= wrData;
        end
      end

      assign statusQ[s] = statusR;
      assign enableQ[s] = enableR;
      assign lowPend[s] = |(statusR & enableR & ~HIGH_MASK);
    end
    assign statusFlat[s*WORD_W +: WORD_W] = statusQ[s];
  end

  // Control word: bit 0 global enable, bits 15..1 level mask
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ctrlQ <= '0;
    else if (strobe.wrControl) ctrlQ <= wrData[15:0];
  end

  // Gather pending sources per level from the fixed table
  always_comb begin
    logic [LEVEL_W-1:0] lvl;
    levelPend = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      for (int b = 0; b < WORD_W; b++) begin
        lvl = srcLevel(s, b);
        if (lvl != '0) levelPend[lvl] = levelPend[lvl] | statusQ[s][b];
      end
    end
  end

  assign levelLive = levelPend & {ctrlQ[15:1], 1'b0};

  always_comb begin
    vector = '0;
    for (int l = 1; l <= NUM_LEVEL; l++) begin
      if (levelLive[l]) vector = LEVEL_W'(l);
    end
  end

  assign globalEn = ctrlQ[0];
  assign highFlag = (vector != '0);
  assign lowFlag  = |lowPend;

  always_comb begin
    case (strobe.rdSel)
      RD_STATUS:  rdData = statusQ[setIdx];
      RD_ENABLE:  rdData = enableQ[setIdx];
      RD_SUMMARY: rdData = {22'b0, highFlag, lowFlag, 4'b0, vector};
      RD_CONTROL: rdData = {16'b0, ctrlQ};
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/icu_two_tier.sv
module icu_two_tier
  import icu_pkg::*;
#(
  parameter int NUM_SETS     = 8,
  parameter int SUMMARY_SET  = 6,
  parameter int NUM_PINS     = 7,
  parameter int PIN_SET      = 5,
  parameter int PIN_POS_BASE = 7,
  parameter int PIN_NEG_BASE = 0,
  localparam int SET_W       = $clog2(NUM_SETS),
  localparam int ADDR_W      = SET_W + 2,
  localparam int LINE_W      = NUM_SETS * 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] srcPulse,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irqHigh,
  output logic              irqLow
);

  icu_strobe_t         strobe;
  logic [SET_W-1:0]    setIdx;
  logic [NUM_PINS-1:0] pinRise;
  logic [NUM_PINS-1:0] pinFall;
  logic [LINE_W-1:0]   pinMap;
  logic [LINE_W-1:0]   pulseAll;
  logic [LINE_W-1:0]   statusFlat;
  logic                globalEn;
  logic                highFlag;
  logic                lowFlag;

  icu_edge #(.NUM_PINS(NUM_PINS)) i_edge (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .pinRise(pinRise),
    .pinFall(pinFall)
  );

  always_comb begin
    pinMap = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      pinMap[PIN_SET*32 + PIN_POS_BASE + i] = pinRise[i];
      pinMap[PIN_SET*32 + PIN_NEG_BASE + i] = pinFall[i];
    end
  end

  assign pulseAll = srcPulse | pinMap;

  icu_ctrl #(.NUM_SETS(NUM_SETS), .SUMMARY_SET(SUMMARY_SET)) i_ctrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .strobe(strobe),
    .setIdx(setIdx)
  );

  icu_datapath #(.NUM_SETS(NUM_SETS), .SUMMARY_SET(SUMMARY_SET)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .setIdx    (setIdx),
    .wrData    (wrData),
    .pulseFlat (pulseAll),
    .rdData    (rdData),
    .statusFlat(statusFlat),
    .globalEn  (globalEn),
    .highFlag  (highFlag),
    .lowFlag   (lowFlag)
  );

  assign irqHigh = globalEn & highFlag;
  assign irqLow  = globalEn & lowFlag & ~highFlag;

endmodule

// File: rtl/icu_two_tier_chk.sv
module icu_two_tier_chk #(
  parameter int NUM_SETS    = 8,
  parameter int SUMMARY_SET = 6,
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int ADDR_W     = SET_W + 2,
  localparam int LINE_W     = NUM_SETS * 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic [LINE_W-1:0] pulseAll,
  input logic [LINE_W-1:0] statusFlat,
  input logic              irqHigh,
  input logic              irqLow
);

  localparam logic [SET_W-1:0] SUM_IDX = SET_W'(SUMMARY_SET);

  logic [SET_W-1:0]  setSel;
  logic [LINE_W-1:0] clrFlat;
  logic [LINE_W-1:0] srcMask;
  logic              ctrlOffWr;

  assign setSel = addr[ADDR_W-1:2];

  always_comb begin
    clrFlat = '0;
    if (wrEn && addr[1:0] == 2'd2 && setSel != '0 && setSel != SUM_IDX)
      clrFlat[int'(setSel)*32 +: 32] = wrData;
  end

  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      srcMask[s*32 +: 32] = (s == 0 || s == SUMMARY_SET) ? 32'h0 : 32'hFFFF_FFFF;
    end
  end

  assign ctrlOffWr = wrEn && (addr == {SUM_IDX, 2'd1}) && !wrData[0];

  AST_CLEAR_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (|clrFlat) |=> ((statusFlat & $past(clrFlat & ~pulseAll)) == '0)); // R2

  AST_PULSE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (|(pulseAll & srcMask)) |=> ((statusFlat & $past(pulseAll & srcMask)) == $past(pulseAll & srcMask))); // R1

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusFlat & ~$past(statusFlat) & ~$past(pulseAll)) == '0)); // R1

  AST_GLOBAL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ctrlOffWr |=> (!irqHigh && !irqLow)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!irqHigh && !irqLow)); // R10

endmodule

bind icu_two_tier icu_two_tier_chk #(.NUM_SETS(NUM_SETS), .SUMMARY_SET(SUMMARY_SET)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .pulseAll  (pulseAll),
  .statusFlat(statusFlat),
  .irqHigh   (irqHigh),
  .irqLow    (irqLow)
);

// File: tb/test_icu_two_tier.sv
module test_icu_two_tier;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SETS   = 8;
  localparam int NUM_PINS   = 7;
  localparam int LINE_W     = NUM_SETS * 32;
  localparam int ADDR_W     = 5;

  logic              clk = 1'b0;
  logic              rstN;
  logic [LINE_W-1:0] srcPulse;
  logic [NUM_PINS-1:0] pinIn;
  logic              wrEn;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wrData;
  logic [31:0]       rdData;
  logic              irqHigh;
  logic              irqLow;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  icu_two_tier i_icu_two_tier (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .pinIn(pinIn),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .irqHigh(irqHigh), .irqLow(irqLow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected level per R4
  function automatic int expLevel(input int s, input int b);
    if (s == 5 && (b == 24 || b == 25)) return 15;
    if (s == 5 && b == 30) return 14;
    if (s == 5 && b == 29) return 13;
    if (s == 1 && b == 18) return 4;
    if (s == 1 && b == 17) return 3;
    if (s == 1 && b == 27) return 2;
    if (s == 5 && (b == 0 || b == 7)) return 1;
    return 0;
  endfunction

  function automatic logic [ADDR_W-1:0] regAddr(input int s, input int k);
    return {3'(s), 2'(k)};
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int s, input int k, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = regAddr(s, k); wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input int s, input int k, output logic [31:0] d);
    @(negedge clk);
    addr = regAddr(s, k);
    #1;
    d = rdData;
  endtask

  task automatic pulse(input int s, input int b);
    @(negedge clk);
    srcPulse[s*32 + b] = 1'b1;
    @(negedge clk);
    srcPulse = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    logic [31:0] v;
    int hiSet [9] = '{5, 5, 5, 5, 1, 1, 1, 5, 5};
    int hiBit [9] = '{25, 24, 30, 29, 18, 17, 27, 7, 0};
    rstN = 1'b0; srcPulse = '0; pinIn = '0; wrEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "irqHigh in reset", 32'(irqHigh), 0);
    chk("R10", "irqLow in reset", 32'(irqLow), 0);
    @(negedge clk); rstN = 1'b1;
    rd(6, 0, v); chk("R10", "summary after reset", v, 0);
    rd(6, 1, v); chk("R10", "control after reset", v, 0);
    rd(5, 0, v); chk("R10", "status5 after reset", v, 0);
    rd(2, 1, v); chk("R10", "enable2 after reset", v, 0);

    // Low-tier sweep over every non-high bit of every source set
    wr(6, 1, 32'h1);
    for (int si = 0; si < 6; si++) begin
      int s;
      s = (si == 5) ? 7 : si + 1;
      for (int b = 0; b < 32; b++) begin
        if (expLevel(s, b) == 0) begin
          pulse(s, b);
          rd(s, 0, v); chk("R1", "status latched without enable", v, 32'h1 << b);
          chk("R3", "irqLow with enable off", 32'(irqLow), 0);
          wr(s, 1, 32'h1 << b);
          rd(6, 0, v); chk("R7", "summary LOW flag", v, 32'h100);
          chk("R3", "irqLow with enable on", 32'(irqLow), 1);
          chk("R3", "irqHigh stays low", 32'(irqHigh), 0);
          wr(s, 2, 32'h1 << b);
          rd(s, 0, v); chk("R2", "status after clear", v, 0);
          chk("R3", "irqLow after clear", 32'(irqLow), 0);
          wr(s, 1, 32'h0);
        end
      end
    end

    // High-tier sweep over the fixed table
    for (int e = 0; e < 9; e++) begin
      int lvl;
      lvl = expLevel(hiSet[e], hiBit[e]);
      pulse(hiSet[e], hiBit[e]);
      wr(6, 1, 32'hFFFF & ~(32'h1 << lvl));
      rd(6, 0, v); chk("R5", "vector with own level masked", v, 0);
      chk("R5", "irqHigh with own level masked", 32'(irqHigh), 0);
      wr(6, 1, 32'h1 | (32'h1 << lvl));
      rd(6, 0, v); chk("R4", "summary level of table entry", v, 32'h200 | 32'(lvl));
      chk("R6", "irqHigh with level unmasked", 32'(irqHigh), 1);
      wr(hiSet[e], 2, 32'h1 << hiBit[e]);
      rd(6, 0, v); chk("R6", "vector after clear", v, 0);
    end

    // Highest level wins
    wr(6, 1, 32'hFFFF);
    pulse(1, 18); pulse(5, 30);
    rd(6, 0, v); chk("R6", "highest of 4 and 14", v, 32'h200 | 14);
    wr(5, 2, 32'h1 << 30);
    rd(6, 0, v); chk("R6", "level 4 after 14 cleared", v, 32'h200 | 4);
    wr(1, 2, 32'h1 << 18);
    chk("R8", "irqHigh with nothing pending", 32'(irqHigh), 0);

    // Shared level
    pulse(5, 25); pulse(5, 24);
    rd(6, 0, v); chk("R6", "both level-15 sources", v, 32'h200 | 15);
    wr(5, 2, 32'h1 << 25);
    rd(6, 0, v); chk("R6", "one level-15 source left", v, 32'h200 | 15);
    wr(5, 2, 32'h1 << 24);
    rd(6, 0, v); chk("R6", "no level-15 source", v, 0);

    // Enable bits at high positions have no effect
    wr(6, 1, 32'h1);
    wr(5, 1, 32'hFFFF_FFFF);
    pulse(5, 30);
    rd(6, 0, v); chk("R5", "enable on masked high source", v, 0);
    chk("R5", "irqLow from high source", 32'(irqLow), 0);
    wr(5, 2, 32'hFFFF_FFFF);
    wr(5, 1, 32'h0);

    // Precedence of the high tier
    wr(6, 1, 32'hFFFF);
    wr(2, 1, 32'h10);
    pulse(2, 4);
    rd(6, 0, v); chk("R3", "irqLow before high arrives", 32'(irqLow), 1);
    pulse(5, 29);
    rd(6, 0, v); chk("R7", "summary with both tiers", v, 32'h30D);
    chk("R9", "irqLow held under irqHigh", 32'(irqLow), 0);
    chk("R9", "irqHigh asserted", 32'(irqHigh), 1);
    wr(5, 2, 32'h1 << 29);
    rd(6, 0, v); chk("R9", "irqLow back after high cleared", 32'(irqLow), 1);

    // Global enable off
    wr(6, 1, 32'hFFFE);
    rd(6, 0, v); chk("R8", "irqLow with global off", 32'(irqLow), 0);
    pulse(5, 30);
    rd(5, 0, v); chk("R8", "status latches with global off", v, 32'h1 << 30);
    chk("R8", "irqHigh with global off", 32'(irqHigh), 0);
    wr(6, 1, 32'hFFFF);
    rd(6, 0, v); chk("R8", "irqHigh after global on", 32'(irqHigh), 1);
    wr(5, 2, 32'hFFFF_FFFF); wr(2, 2, 32'hFFFF_FFFF); wr(2, 1, 32'h0);

    // Partial clear, and pulse against clear in the same cycle
    @(negedge clk);
    srcPulse[3*32 + 2] = 1'b1; srcPulse[3*32 + 5] = 1'b1; srcPulse[3*32 + 9] = 1'b1;
    @(negedge clk); srcPulse = '0;
    wr(3, 2, 32'h24);
    rd(3, 0, v); chk("R2", "only written bits cleared", v, 32'h200);
    @(negedge clk);
    srcPulse[3*32 + 9] = 1'b1;
    wrEn = 1'b1; addr = regAddr(3, 2); wrData = 32'h200;
    @(negedge clk);
    srcPulse = '0; wrEn = 1'b0; wrData = '0;
    rd(3, 0, v); chk("R2", "pulse wins over clear", v, 32'h200);
    wr(3, 2, 32'h200);

    // Non-source sets and address map
    @(negedge clk);
    srcPulse[31:0] = '1; srcPulse[6*32 +: 32] = '1;
    @(negedge clk); srcPulse = '0;
    rd(0, 0, v); chk("R1", "set 0 status", v, 0);
    rd(6, 0, v); chk("R1", "summary after set 6 pulses", v, 0);
    wr(1, 0, 32'hFFFF_FFFF);
    rd(1, 0, v); chk("R12", "write to status ignored", v, 0);
    wr(1, 3, 32'hFFFF_FFFF);
    rd(1, 3, v); chk("R12", "spare reads zero", v, 0);
    wr(4, 1, 32'h1234_5678);
    rd(4, 1, v); chk("R12", "enable read back", v, 32'h1234_5678);
    rd(4, 2, v); chk("R12", "clear address reads zero", v, 0);
    wr(4, 1, 32'h0);

    // Pin edges
    for (int i = 0; i < NUM_PINS; i++) begin
      @(negedge clk); pinIn[i] = 1'b1;
      rd(5, 0, v); chk("R11", "rising edge bit", v, 32'h1 << (7 + i));
      wr(5, 2, 32'hFFFF_FFFF);
      @(negedge clk); pinIn[i] = 1'b0;
      rd(5, 0, v); chk("R11", "falling edge bit", v, 32'h1 << i);
      wr(5, 2, 32'hFFFF_FFFF);
    end

    done = 1'b1;
    finishRun();
  end

endmodule